// File: doc/BRIEF.md
# Register-Pair Stack Sequencer

This block carries out the stack side of a processor with 8-bit data and 16-bit addresses. It holds the stack pointer and turns one command into the right run of single-byte memory accesses. The commands are: save a register pair, restore a register pair, save a return address and jump (call), restore a return address (return), swap a pair with the two bytes at the stack top, and load the stack pointer. The stack grows toward lower addresses.

A command is taken when `cmd_valid` is high and the block is idle. The block then issues one memory request at a time and holds it until `mem_rdy` acknowledges it. `done` pulses for one cycle when the command finishes. `pc_load` pulses together with `done` for calls and returns, and `pc_out` then carries the new program counter. Instruction decode and the memory itself sit outside this block.

States: `S_IDLE` (waiting for a command), `S_WR_HI` and `S_WR_LO` (save, high byte then low byte), `S_RD_LO` and `S_RD_HI` (restore, low byte then high byte), and `S_XR_LO`, `S_XW_LO`, `S_XR_HI`, `S_XW_HI` (swap: read and then write at SP, then read and then write at SP+1). Transitions: a save or call moves from idle to `S_WR_HI`. A restore or return moves to `S_RD_LO`. A swap moves to `S_XR_LO`. Each non-idle state advances to the next one in its chain on an acknowledged access. The last state of each chain returns to `S_IDLE`. A stack-pointer load, and an unused opcode, stay in `S_IDLE`.

Top module: `stack_pair_seq`

## Requirements
- R1: After reset `sp_out` is 0x0000, and `busy`, `done`, `pc_load` and `mem_req` are all 0.
- R2: Save (`cmd_op` 0) decrements SP and writes `cmd_hi` at the new SP. It then decrements SP again and writes `cmd_lo`. SP ends 2 below its start.
- R3: Restore (`cmd_op` 1) reads the byte at SP into `res_lo`, increments SP, reads the byte there into `res_hi`, and increments SP again.
- R4: Call (`cmd_op` 4) saves the return address, given as `cmd_hi`/`cmd_lo`, in the same order as R2. When it finishes it pulses `pc_load` with `pc_out` equal to `cmd_target`.
- R5: Return (`cmd_op` 5) reads the two bytes at the stack top in the same order as R3. It pulses `pc_load` with `pc_out` = {byte at SP+1, byte at SP} and leaves SP 2 higher.
- R6: Swap (`cmd_op` 3) reads SP, writes `cmd_lo` at SP, reads SP+1, then writes `cmd_hi` at SP+1. It returns the old bytes on `res_hi`/`res_lo` and leaves SP unchanged.
- R7: Load (`cmd_op` 2) sets SP to {`cmd_hi`,`cmd_lo`} in the cycle after acceptance and pulses `done` in that cycle. Opcodes 6 and 7 make no access and change nothing.
- R8: Each access is one request. Address, direction and write data stay stable while `mem_rdy` is low, and the sequence advances only on `mem_req` and `mem_rdy` both high.
- R9: SP wraps modulo 2^16 on both increment and decrement.
- R10: `busy` is high from acceptance until the last byte is acknowledged. Commands offered while busy are ignored. `mem_req` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Opcode: 0 save, 1 restore, 2 load SP, 3 swap, 4 call, 5 return |
| cmd_hi | input | 8 | High byte of the pair operand |
| cmd_lo | input | 8 | Low byte of the pair operand |
| cmd_target | input | 16 | Call destination |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 8 | High byte read back |
| res_lo | output | 8 | Low byte read back |
| pc_load | output | 1 | New program counter valid (call or return) |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rdy | input | 1 | Access acknowledge |

## Verification
A stuck or skipped sequencer state shows up at the very next acknowledged access. That access then carries the wrong address, the wrong direction or the wrong byte, and the access-by-access scoreboard catches it. A wrong stack pointer stays hidden until a later command uses it. It then appears as a wrong first address or as a wrong `sp_out` after `done`, so each command is followed by a check of `sp_out`. A wrong captured byte shows up only on `res_hi`/`res_lo` or `pc_out` in the `done` cycle, where it is compared against the bench's own memory model.

// File: rtl/stack_pair_pkg.sv
package stack_pair_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_LDSP = 3'd2,
        OP_XCHG = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC,
        SP_LOAD
    } sp_act_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_HI,
        S_WR_LO,
        S_RD_LO,
        S_RD_HI,
        S_XR_LO,
        S_XW_LO,
        S_XR_HI,
        S_XW_HI
    } seq_state_e;
endpackage

// File: rtl/stack_sp_reg.sv
module stack_sp_reg
    import stack_pair_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_act_e       act,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else begin
            unique case (act)
                SP_DEC:  sp <= sp - ONE;
                SP_INC:  sp <= sp + ONE;
                SP_LOAD: sp <= load_val;
                default: sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/stack_pair_capture.sv
module stack_pair_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_lo,
    input  logic          cap_hi,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] lo
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else begin
            if (cap_lo) lo <= din;
            if (cap_hi) hi <= din;
        end
    end
endmodule

// File: rtl/stack_pair_seq.sv
module stack_pair_seq
    import stack_pair_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_hi,
    input  logic [DW-1:0] cmd_lo,
    input  logic [AW-1:0] cmd_target,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rdy
);
    localparam logic [AW-1:0] ONE = AW'(1);

    seq_state_e    state, state_nxt;
    sp_act_e       sp_act;
    logic          cap_lo, cap_hi;
    logic          step, finish, accept;
    logic [DW-1:0] op_hi_q, op_lo_q;
    logic [AW-1:0] tgt_q, pc_q;
    logic          is_call_q, is_ret_q, done_q, pcl_q;

    assign accept = cmd_valid && (state == S_IDLE);
    assign step   = mem_req && mem_rdy;

    stack_sp_reg #(.AW(AW)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (sp_act),
        .load_val ({cmd_hi, cmd_lo}),
        .sp       (sp_out)
    );

    stack_pair_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .din    (mem_rdata),
        .hi     (res_hi),
        .lo     (res_lo)
    );

    // next state, stack-pointer action and capture strobes
    always_comb begin
        state_nxt = state;
        sp_act    = SP_HOLD;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        finish    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_PUSH, OP_CALL: begin
                            sp_act    = SP_DEC;
                            state_nxt = S_WR_HI;
                        end
                        OP_POP, OP_RET: state_nxt = S_RD_LO;
                        OP_XCHG:        state_nxt = S_XR_LO;
                        OP_LDSP:        sp_act    = SP_LOAD;
                        default:        state_nxt = S_IDLE;
                    endcase
                end
            end
            S_WR_HI: if (step) begin sp_act = SP_DEC; state_nxt = S_WR_LO; end
            S_WR_LO: if (step) begin finish = 1'b1; state_nxt = S_IDLE; end
            S_RD_LO: if (step) begin cap_lo = 1'b1; sp_act = SP_INC; state_nxt = S_RD_HI; end
            S_RD_HI: if (step) begin
                cap_hi = 1'b1; sp_act = SP_INC; finish = 1'b1; state_nxt = S_IDLE;
            end
            S_XR_LO: if (step) begin cap_lo = 1'b1; state_nxt = S_XW_LO; end
            S_XW_LO: if (step) state_nxt = S_XR_HI;
            S_XR_HI: if (step) begin cap_hi = 1'b1; state_nxt = S_XW_HI; end
            S_XW_HI: if (step) begin finish = 1'b1; state_nxt = S_IDLE; end
            default: state_nxt = S_IDLE;
        endcase
    end

    // state register and per-command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_hi_q   <= '0;
            op_lo_q   <= '0;
            tgt_q     <= '0;
            pc_q      <= '0;
            is_call_q <= 1'b0;
            is_ret_q  <= 1'b0;
            done_q    <= 1'b0;
            pcl_q     <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= finish || (accept && cmd_op == OP_LDSP);
            pcl_q  <= finish && (is_call_q || is_ret_q);
            if (accept) begin
                op_hi_q   <= cmd_hi;
                op_lo_q   <= cmd_lo;
                tgt_q     <= cmd_target;
                is_call_q <= (cmd_op == OP_CALL);
                is_ret_q  <= (cmd_op == OP_RET);
            end
            if (finish && is_call_q) pc_q <= tgt_q;
            if (finish && is_ret_q)  pc_q <= {mem_rdata, res_lo};
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = (state != S_IDLE);
        mem_we    = 1'b0;
        mem_addr  = sp_out;
        mem_wdata = '0;
        unique case (state)
            S_WR_HI: begin mem_we = 1'b1; mem_wdata = op_hi_q; end
            S_WR_LO: begin mem_we = 1'b1; mem_wdata = op_lo_q; end
            S_XW_LO: begin mem_we = 1'b1; mem_wdata = op_lo_q; end
            S_XR_HI: mem_addr = sp_out + ONE;
            S_XW_HI: begin mem_we = 1'b1; mem_wdata = op_hi_q; mem_addr = sp_out + ONE; end
            default: ;
        endcase
    end

    assign done    = done_q;
    assign pc_load = pcl_q;
    assign pc_out  = pc_q;
endmodule

// File: rtl/stack_pair_seq_chk.sv
module stack_pair_seq_chk #(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [DW-1:0] cmd_hi,
    input logic [DW-1:0] cmd_lo,
    input logic [AW-1:0] cmd_target,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] res_hi,
    input logic [DW-1:0] res_lo,
    input logic          pc_load,
    input logic [AW-1:0] pc_out,
    input logic [AW-1:0] sp_out,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_rdy
);
    logic take;
    assign take = cmd_valid && !busy;

    p_push_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op == 3'd0 || cmd_op == 3'd4) |=>
            mem_req && mem_we && mem_addr == AW'($past(sp_out) - 1) && mem_wdata == $past(cmd_hi));

    p_pop_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op == 3'd1 || cmd_op == 3'd5) |=>
            mem_req && !mem_we && mem_addr == $past(sp_out));

    p_xchg_keeps_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op == 3'd3 |=> mem_req && !mem_we && sp_out == $past(sp_out));

    p_ldsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op == 3'd2 |=> sp_out == $past({cmd_hi, cmd_lo}) && done && !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=>
            mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(mem_req && mem_rdy) |=> $stable(sp_out));
endmodule

bind stack_pair_seq stack_pair_seq_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_stack_pair_seq.sv
module tb_stack_pair_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_hi = 8'h00, cmd_lo = 8'h00;
    logic [15:0] cmd_target = 16'h0000;
    logic        busy, done, pc_load, mem_req, mem_we;
    logic [7:0]  res_hi, res_lo, mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_rdy = 1'b0;
    logic [15:0] pc_out, sp_out, mem_addr;

    int tests = 0, fails = 0;
    int wait_cfg = 0, wcnt = 0;
    logic [7:0] mem [int];

    typedef struct { bit we; logic [15:0] addr; logic [7:0] data; string tag; } acc_t;
    acc_t exp_q[$];

    bit          hold_chk = 0;
    logic [15:0] h_addr;
    logic        h_we;
    logic [7:0]  h_wd;

    always #2.5 clk = ~clk;

    stack_pair_seq dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic expect_acc(input bit we, input logic [15:0] a, input logic [7:0] d, input string tag);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // memory model and access scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy = 1'b0; wcnt = wait_cfg; hold_chk = 0;
        end else if (mem_req) begin
            if (hold_chk)
                chk(mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wd,
                    "R8 request held stable", {15'd0, mem_we, mem_addr}, {15'd0, h_we, h_addr});
            if (wcnt == 0) begin
                mem_rdy   = 1'b1;
                mem_rdata = rd(mem_addr);
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                        e.tag, {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e.we, e.addr, e.data});
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                wcnt = wait_cfg; hold_chk = 0;
            end else begin
                mem_rdy = 1'b0; wcnt--; hold_chk = 1;
                h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
            end
        end else begin
            mem_rdy = 1'b0; hold_chk = 0;
        end
    end

    logic       seen_pcl;
    logic [15:0] seen_pc;

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] hi, input logic [7:0] lo,
                           input logic [15:0] tgt, input string tag);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_hi = hi; cmd_lo = lo; cmd_target = tgt;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && n < 50) begin
            chk(busy == 1'b1, {tag, " R10 busy until last byte"}, busy, 1);
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1 && busy == 1'b0, {tag, " done pulse"}, {busy, done}, 2'b01);
        seen_pcl = pc_load; seen_pc = pc_out;
        chk(exp_q.size() == 0, {tag, " all accesses made"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sp_out == 16'h0000, "R1 sp after reset", sp_out, 0);
        chk({busy, done, pc_load, mem_req} == 4'b0, "R1 idle outputs", {busy, done, pc_load, mem_req}, 0);

        // R7 load SP
        run_cmd(3'd2, 8'h20, 8'h00, 16'h0, "R7 load");
        chk(sp_out == 16'h2000, "R7 sp loaded", sp_out, 16'h2000);

        // R2 save
        expect_acc(1, 16'h1FFF, 8'h12, "R2 high byte first");
        expect_acc(1, 16'h1FFE, 8'h34, "R2 low byte second");
        run_cmd(3'd0, 8'h12, 8'h34, 16'h0, "R2 push");
        chk(sp_out == 16'h1FFE, "R2 sp after push", sp_out, 16'h1FFE);

        // R8 save with wait states
        wait_cfg = 2;
        expect_acc(1, 16'h1FFD, 8'h56, "R8 push hi with waits");
        expect_acc(1, 16'h1FFC, 8'h78, "R8 push lo with waits");
        run_cmd(3'd0, 8'h56, 8'h78, 16'h0, "R8 push");
        chk(sp_out == 16'h1FFC, "R8 sp after waited push", sp_out, 16'h1FFC);

        // R3 restore (still with waits)
        expect_acc(0, 16'h1FFC, 8'h00, "R3 read low at sp");
        expect_acc(0, 16'h1FFD, 8'h00, "R3 read high at sp+1");
        run_cmd(3'd1, 8'h00, 8'h00, 16'h0, "R3 pop");
        chk({res_hi, res_lo} == 16'h5678, "R3 popped pair", {res_hi, res_lo}, 16'h5678);
        chk(sp_out == 16'h1FFE, "R3 sp after pop", sp_out, 16'h1FFE);
        wait_cfg = 0;

        // R4 call
        expect_acc(1, 16'h1FFD, 8'h04, "R4 return hi");
        expect_acc(1, 16'h1FFC, 8'h56, "R4 return lo");
        run_cmd(3'd4, 8'h04, 8'h56, 16'hABCD, "R4 call");
        chk(seen_pcl == 1'b1 && seen_pc == 16'hABCD, "R4 new pc", {seen_pcl, seen_pc}, 17'h1ABCD);
        chk(sp_out == 16'h1FFC, "R4 sp after call", sp_out, 16'h1FFC);

        // R5 return
        expect_acc(0, 16'h1FFC, 8'h00, "R5 read low");
        expect_acc(0, 16'h1FFD, 8'h00, "R5 read high");
        run_cmd(3'd5, 8'h00, 8'h00, 16'h0, "R5 ret");
        chk(seen_pcl == 1'b1 && seen_pc == 16'h0456, "R5 restored pc", {seen_pcl, seen_pc}, 17'h10456);
        chk(sp_out == 16'h1FFE, "R5 sp after ret", sp_out, 16'h1FFE);

        // R6 swap with stack top (top holds 12/34)
        expect_acc(0, 16'h1FFE, 8'h00, "R6 read sp");
        expect_acc(1, 16'h1FFE, 8'h22, "R6 write lo at sp");
        expect_acc(0, 16'h1FFF, 8'h00, "R6 read sp+1");
        expect_acc(1, 16'h1FFF, 8'h11, "R6 write hi at sp+1");
        run_cmd(3'd3, 8'h11, 8'h22, 16'h0, "R6 xchg");
        chk({res_hi, res_lo} == 16'h1234, "R6 old top returned", {res_hi, res_lo}, 16'h1234);
        chk(sp_out == 16'h1FFE, "R6 sp unchanged", sp_out, 16'h1FFE);
        chk(seen_pcl == 1'b0, "R6 no pc load", seen_pcl, 0);
        expect_acc(0, 16'h1FFE, 8'h00, "R6 readback lo");
        expect_acc(0, 16'h1FFF, 8'h00, "R6 readback hi");
        run_cmd(3'd1, 8'h00, 8'h00, 16'h0, "R6 pop");
        chk({res_hi, res_lo} == 16'h1122, "R6 swapped pair in memory", {res_hi, res_lo}, 16'h1122);
        chk(sp_out == 16'h2000, "R6 sp after pop", sp_out, 16'h2000);

        // R9 wrap
        run_cmd(3'd2, 8'h00, 8'h01, 16'h0, "R9 load");
        expect_acc(1, 16'h0000, 8'h77, "R9 push hi at 0000");
        expect_acc(1, 16'hFFFF, 8'h88, "R9 push lo wraps to FFFF");
        run_cmd(3'd0, 8'h77, 8'h88, 16'h0, "R9 push");
        chk(sp_out == 16'hFFFF, "R9 sp wrapped down", sp_out, 16'hFFFF);
        expect_acc(0, 16'hFFFF, 8'h00, "R9 pop lo at FFFF");
        expect_acc(0, 16'h0000, 8'h00, "R9 pop hi wraps to 0000");
        run_cmd(3'd1, 8'h00, 8'h00, 16'h0, "R9 pop");
        chk({res_hi, res_lo} == 16'h7788, "R9 pair across wrap", {res_hi, res_lo}, 16'h7788);
        chk(sp_out == 16'h0001, "R9 sp wrapped up", sp_out, 16'h0001);

        // R7 unused opcode does nothing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_hi = 8'h99; cmd_lo = 8'h99;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) begin
            chk(!busy && !done && sp_out == 16'h0001, "R7 opcode 6 ignored", {busy, done, sp_out}, 16'h0001);
            @(negedge clk);
        end

        // R10 command offered while busy is ignored
        wait_cfg = 1;
        expect_acc(1, 16'h0000, 8'hC3, "R10 push hi");
        expect_acc(1, 16'hFFFF, 8'h3C, "R10 push lo");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_hi = 8'hC3; cmd_lo = 8'h3C;
        @(negedge clk);
        cmd_op = 3'd2; cmd_hi = 8'h55; cmd_lo = 8'h55;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R10 busy drops with done", busy, 0);
        chk(sp_out == 16'hFFFF, "R10 load during busy ignored", sp_out, 16'hFFFF);
        @(negedge clk);
        chk(!done && !mem_req, "R10 idle after command", {done, mem_req}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule